// File: doc/BRIEF.md
# Supply Brownout and Power-On Supervisor

This block is the digital side of supply-voltage supervision. A bank of analog comparators outside the block reports whether the supply sits below each of several trip levels. The block synchronises each of these reports and filters out short glitches. It then derives three independent brownout functions from them. The reset request and the interrupt each pick their own trip level through a small configuration field. The flash/EEPROM write-inhibit uses a comparator with one fixed trip level.

The current power mode gates the three functions in different ways. The reset request cannot be turned off by software and is silenced only in total power-down. The write-inhibit is silenced in both power-down modes. The interrupt is enabled by software and latches as a pending flag that software clears by writing one. A separate power-on flag records an initial power-up and stays set until software clears it. The block also raises a configuration error whenever the reset level is not strictly below the interrupt level.

All pins are plain control and status lines, with no streaming interface. The power-mode and configuration inputs are assumed to be stable, synchronous register outputs.

Top module: `bod_supervisor`

## Requirements
- R1: During and directly after reset, bo_rst_req, bo_int_pend and flash_inhibit are 0 and por_flag is 1.
- R2: Every comparator input passes through a two-flop synchronizer and then a glitch filter. The filtered condition takes a new value only after the synchronized value has differed from it for N consecutive cycles, where N = cfg_filt_len (a value of 0 acts as 1). A change held on an input therefore appears 2+N clock edges later. A pulse that lasts fewer than N cycles is ignored.
- R3: bo_rst_req is 1 while the filtered condition at the level chosen by cfg_rst_lvl is 1 and pwr_mode is not 3. It falls when the condition clears. No configuration input can disable it.
- R4: flash_inhibit follows the filtered cmp_prot_below condition in pwr_mode 0 (run) and 1 (idle), and is 0 in pwr_mode 2 (power-down) and 3 (total power-down).
- R5: Bit k of cmp_below means the supply is below trip level k, with level 0 the lowest. The reset function uses level cfg_rst_lvl and the interrupt function uses level cfg_int_lvl, and the two choices are independent.
- R6: bo_int_pend sets on the edge after the filtered condition at level cfg_int_lvl is seen while cfg_int_en is 1. It never sets while cfg_int_en is 0. It stays set until int_clr is 1 at an edge, and a set in that same cycle wins over the clear.
- R7: por_evt sets por_flag at the next edge. por_clr clears it at the next edge only when por_evt is 0 in that cycle; otherwise the flag stays set.
- R8: cfg_err is 1, combinationally, exactly when cfg_rst_lvl >= cfg_int_lvl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_below | input | NUM_LVL (4) | Comparator outputs; bit k = supply below trip level k |
| cmp_prot_below | input | 1 | Comparator for the fixed write-protect level |
| por_evt | input | 1 | Power-on detect event |
| pwr_mode | input | 2 | 0 run, 1 idle, 2 power-down, 3 total power-down |
| cfg_rst_lvl | input | LVL_W (2) | Trip level for the reset request |
| cfg_int_lvl | input | LVL_W (2) | Trip level for the interrupt |
| cfg_int_en | input | 1 | Interrupt enable |
| cfg_filt_len | input | FILT_W (4) | Glitch filter length in cycles |
| int_clr | input | 1 | Write-one-to-clear of the pending interrupt |
| por_clr | input | 1 | Software clear of the power-on flag |
| bo_rst_req | output | 1 | Brownout reset request |
| bo_int_pend | output | 1 | Brownout interrupt pending |
| flash_inhibit | output | 1 | Flash/EEPROM program/erase inhibit |
| por_flag | output | 1 | Power-on flag |
| cfg_err | output | 1 | Trip level configuration error |

## Verification
The assertions check several properties on every cycle. A filtered condition holds still while it matches its synchronized input. Total power-down silences the reset request, and both power-down modes silence the write-inhibit. Both sticky flags hold until they are cleared, and a power-on event always leaves its flag set. The pending interrupt never rises while it is disabled. The bench scenarios are needed to show the exact 2+N-edge latency and glitch rejection for a given filter length, and the correct mapping of each configured level onto its comparator bit. They also show the set-over-clear priority of the sticky flags under colliding stimulus.

// File: rtl/bod_pkg.sv
package bod_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_PD   = 2'd2,
    PM_TPD  = 2'd3
  } pmode_e;
endpackage

// File: rtl/bod_cond_filter.sv
module bod_cond_filter #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned CW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw,
  input  logic [CW-1:0] len,
  output logic          cond
);
  logic [STAGES-1:0] sync_q;
  logic [CW-1:0]     cnt_q;
  logic [CW:0]       thr;
  logic [CW:0]       cnt_inc;
  logic              sync_v;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= raw;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], raw};
    end
  endgenerate

  assign sync_v  = sync_q[STAGES-1];
  assign thr     = (len == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, len};
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond  <= 1'b0;
      cnt_q <= '0;
    end else if (sync_v == cond) begin
      cnt_q <= '0;
    end else if (cnt_inc >= thr) begin
      cond  <= sync_v;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_inc[CW-1:0];
    end
  end

  // R2: the filtered value only moves after a mismatch with the synchronizer
  a_r2_hold_when_matched: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_v == cond) |=> $stable(cond))
    else $error("R2 filtered condition changed without a mismatch");
endmodule

// File: rtl/bod_sticky_flag.sv
module bod_sticky_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag <= RST_VAL;
    else        flag <= set | (flag & ~clr);

  // R6 R7: set has priority over clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag)
    else $error("R6/R7 set did not win");
endmodule

// File: rtl/bod_supervisor.sv
module bod_supervisor
  import bod_pkg::*;
#(
  parameter int unsigned NUM_LVL     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_W      = 4,
  parameter int unsigned LVL_W       = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] cmp_below,
  input  logic               cmp_prot_below,
  input  logic               por_evt,
  input  logic [1:0]         pwr_mode,
  input  logic [LVL_W-1:0]   cfg_rst_lvl,
  input  logic [LVL_W-1:0]   cfg_int_lvl,
  input  logic               cfg_int_en,
  input  logic [FILT_W-1:0]  cfg_filt_len,
  input  logic               int_clr,
  input  logic               por_clr,
  output logic               bo_rst_req,
  output logic               bo_int_pend,
  output logic               flash_inhibit,
  output logic               por_flag,
  output logic               cfg_err
);
  localparam int unsigned NCH = NUM_LVL + 1;
  localparam int unsigned PROT_IDX = NUM_LVL;

  logic [NCH-1:0] raw_all;
  logic [NCH-1:0] cond;
  pmode_e         mode;
  logic           int_hit;

  assign raw_all = {cmp_prot_below, cmp_below};
  assign mode    = pmode_e'(pwr_mode);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      bod_cond_filter #(.STAGES(SYNC_STAGES), .CW(FILT_W)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_all[i]),
        .len  (cfg_filt_len),
        .cond (cond[i])
      );
    end
  endgenerate

  assign bo_rst_req    = cond[cfg_rst_lvl] && (mode != PM_TPD);
  assign flash_inhibit = cond[PROT_IDX] && (mode == PM_RUN || mode == PM_IDLE);
  assign int_hit       = cfg_int_en && cond[cfg_int_lvl];
  assign cfg_err       = (cfg_rst_lvl >= cfg_int_lvl);

  bod_sticky_flag #(.RST_VAL(1'b0)) u_int_pend (
    .clk(clk), .rst_n(rst_n), .set(int_hit), .clr(int_clr), .flag(bo_int_pend)
  );

  bod_sticky_flag #(.RST_VAL(1'b1)) u_por (
    .clk(clk), .rst_n(rst_n), .set(por_evt), .clr(por_clr), .flag(por_flag)
  );

  a_r3_tpd_silences_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd3) |-> !bo_rst_req)
    else $error("R3 reset request in total power-down");

  a_r4_pd_silences_protect: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode[1] |-> !flash_inhibit)
    else $error("R4 inhibit active in power-down");

  a_r6_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_int_en && !bo_int_pend) |=> !bo_int_pend)
    else $error("R6 pending set while disabled");

  a_r6_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_int_pend && !int_clr) |=> bo_int_pend)
    else $error("R6 pending dropped without clear");

  a_r7_por_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (por_flag && !por_clr) |=> por_flag)
    else $error("R7 power-on flag dropped without clear");
endmodule

// File: tb/bod_supervisor_tb.sv
module bod_supervisor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cmp_below = '0;
  logic       cmp_prot_below = 1'b0;
  logic       por_evt = 1'b0;
  logic [1:0] pwr_mode = 2'd0;
  logic [1:0] cfg_rst_lvl = 2'd0;
  logic [1:0] cfg_int_lvl = 2'd1;
  logic       cfg_int_en = 1'b0;
  logic [3:0] cfg_filt_len = 4'd1;
  logic       int_clr = 1'b0;
  logic       por_clr = 1'b0;
  logic       bo_rst_req, bo_int_pend, flash_inhibit, por_flag, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bod_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_below(cmp_below), .cmp_prot_below(cmp_prot_below),
    .por_evt(por_evt), .pwr_mode(pwr_mode), .cfg_rst_lvl(cfg_rst_lvl),
    .cfg_int_lvl(cfg_int_lvl), .cfg_int_en(cfg_int_en), .cfg_filt_len(cfg_filt_len),
    .int_clr(int_clr), .por_clr(por_clr), .bo_rst_req(bo_rst_req),
    .bo_int_pend(bo_int_pend), .flash_inhibit(flash_inhibit), .por_flag(por_flag),
    .cfg_err(cfg_err)
  );

  // Reference model built from the requirements
  logic [4:0] m_s1, m_s2, m_f;
  int         m_cnt [5];
  logic       m_pend, m_por;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_f = '0; m_pend = 1'b0; m_por = 1'b1;
      for (int i = 0; i < 5; i++) m_cnt[i] = 0;
    end else begin
      int thr;
      m_pend = (cfg_int_en && m_f[cfg_int_lvl]) || (m_pend && !int_clr);
      m_por  = por_evt || (m_por && !por_clr);
      thr = (cfg_filt_len == 0) ? 1 : int'(cfg_filt_len);
      for (int i = 0; i < 5; i++) begin
        if (m_s2[i] == m_f[i]) m_cnt[i] = 0;
        else if (m_cnt[i] + 1 >= thr) begin m_f[i] = m_s2[i]; m_cnt[i] = 0; end
        else m_cnt[i] = m_cnt[i] + 1;
      end
      m_s2 = m_s1;
      m_s1 = {cmp_prot_below, cmp_below};
    end
  end

  function automatic logic exp_rst();
    return m_f[cfg_rst_lvl] && (pwr_mode != 2'd3);
  endfunction
  function automatic logic exp_flash();
    return m_f[4] && (pwr_mode < 2'd2);
  endfunction
  function automatic logic exp_err();
    return cfg_rst_lvl >= cfg_int_lvl;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    check(bo_rst_req,    exp_rst(),   "R3 reset request");
    check(flash_inhibit, exp_flash(), "R4 write inhibit");
    check(bo_int_pend,   m_pend,      "R6 interrupt pending");
    check(por_flag,      m_por,       "R7 power-on flag");
    check(cfg_err,       exp_err(),   "R8 config error");
  endtask

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      #1;
      compare_model();
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset values
    check(bo_rst_req, 1'b0, "R1 rst_req");
    check(bo_int_pend, 1'b0, "R1 int_pend");
    check(flash_inhibit, 1'b0, "R1 inhibit");
    check(por_flag, 1'b1, "R1 por_flag");
    rst_n = 1'b1;
    cyc(2);

    // R2 glitch rejection and exact latency, filter length 3
    cfg_filt_len = 4'd3; cfg_rst_lvl = 2'd1; cfg_int_lvl = 2'd2;
    cmp_below = 4'b0010;
    cyc(2);
    cmp_below = 4'b0000;
    for (int k = 0; k < 8; k++) begin cyc(); check(bo_rst_req, 1'b0, "R2 glitch ignored"); end
    cmp_below = 4'b0010;
    cyc(4);
    check(bo_rst_req, 1'b0, "R2 not before 2+N edges");
    cyc();
    check(bo_rst_req, 1'b1, "R2 asserted at 2+N edges");

    // R5 level selection: only bit 1 low-level set; reset at level 2 must not fire
    cfg_rst_lvl = 2'd2; cfg_int_lvl = 2'd3;
    cyc();
    check(bo_rst_req, 1'b0, "R5 level 2 not selected bit");
    check(cfg_err, 1'b0, "R8 rst<int no error");
    cmp_below = 4'b0100;
    cyc(6);
    check(bo_rst_req, 1'b1, "R5 level 2 follows bit 2");
    cfg_int_lvl = 2'd2;
    #1 check(cfg_err, 1'b1, "R8 equal levels error");
    // R3 mode gating
    pwr_mode = 2'd3;
    #1 check(bo_rst_req, 1'b0, "R3 total power-down silences");
    pwr_mode = 2'd2;
    #1 check(bo_rst_req, 1'b1, "R3 active in power-down");

    // R6 set wins over clear, then clear
    cfg_int_en = 1'b1; pwr_mode = 2'd0;
    cyc();
    check(bo_int_pend, 1'b1, "R6 pending set");
    int_clr = 1'b1;
    cyc();
    check(bo_int_pend, 1'b1, "R6 set wins over clear");
    cfg_int_en = 1'b0;
    cyc();
    check(bo_int_pend, 1'b0, "R6 cleared");
    int_clr = 1'b0;
    cyc(3);
    check(bo_int_pend, 1'b0, "R6 disabled no set");

    // R7 simultaneous event and clear
    por_clr = 1'b1; por_evt = 1'b1;
    cyc();
    check(por_flag, 1'b1, "R7 event wins");
    por_evt = 1'b0;
    cyc();
    check(por_flag, 1'b0, "R7 clear");
    por_clr = 1'b0;

    // R4 protect comparator
    cmp_prot_below = 1'b1; cfg_filt_len = 4'd0;
    cyc(3);
    check(flash_inhibit, 1'b1, "R4 inhibit in run");
    pwr_mode = 2'd2;
    #1 check(flash_inhibit, 1'b0, "R4 off in power-down");

    // Constrained random phase
    for (int blk = 0; blk < 40; blk++) begin
      cfg_filt_len = 4'($urandom_range(0, 4));
      cfg_rst_lvl  = 2'($urandom_range(0, 3));
      cfg_int_lvl  = 2'($urandom_range(0, 3));
      cfg_int_en   = 1'($urandom_range(0, 1));
      for (int c = 0; c < 60; c++) begin
        if ($urandom_range(0, 7) == 0) cmp_below[$urandom_range(0, 3)] ^= 1'b1;
        if ($urandom_range(0, 9) == 0) cmp_prot_below = ~cmp_prot_below;
        if ($urandom_range(0, 15) == 0) pwr_mode = 2'($urandom_range(0, 3));
        int_clr = ($urandom_range(0, 5) == 0);
        por_clr = ($urandom_range(0, 5) == 0);
        por_evt = ($urandom_range(0, 15) == 0);
        cyc();
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule